// File: doc/BRIEF.md
# Modulo Reservation Table

This block keeps the resource reservation grid used by a modulo scheduler while it tries one candidate initiation interval. The grid has one row for each slot 0 to II-1 and one column for each resource class. The classes are two ALUs, one memory port, two buses and a branch unit. A requester presents a schedule time and a resource. The block folds the time into a row by taking it modulo the current interval. It answers one cycle later whether that cell is free. If the request asks to commit and the cell is free, the block marks the cell busy.

A resource therefore can never be claimed at two times whose distance is a multiple of the interval. When a scheduling attempt fails, the controller loads the next interval, which also empties the grid, and starts again. A separate clear input empties the grid without changing the interval.

Top module: `mrt_unit`

## Requirements
- R1: After reset the interval is 1, every cell is free, and no response is pending (`rsp_valid_o` low).
- R2: A request accepted in one cycle produces exactly one cycle of `rsp_valid_o` in the next cycle. `rsp_slot_o` equals the request time modulo the interval in force.
- R3: `rsp_free_o` is 1 when the addressed cell (row = time mod interval, column = resource) was free at the time of the request.
- R4: A committing request (`req_commit_i`=1) on a free cell marks that cell busy. Later requests to the same resource at any time with the same remainder see it busy. Every other cell keeps its state.
- R5: A committing request on a busy cell raises `rsp_conflict_o` and leaves the grid unchanged. A request with `req_commit_i`=0 never changes the grid, and its conflict flag stays low.
- R6: `clr_i` empties the whole grid in one cycle. A request presented in the same cycle is ignored: it gives no response and writes nothing.
- R7: `ii_load_i` loads a new interval and empties the grid in the same cycle. A request presented in that cycle is ignored. A loaded value of 0 is taken as 1, and a value above 16 is taken as 16.
- R8: Resource encoding: 0 first ALU, 1 second ALU, 2 memory port, 3 first bus, 4 second bus, 5 branch unit. The codes 6 and 7 are always reported not free, raise the conflict flag when committing, and write nothing.
- R9: The modulo mapping is correct for every 16-bit time value and every interval from 1 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Empty the grid |
| ii_load_i | input | 1 | Load a new interval (also empties the grid) |
| ii_val_i | input | 5 | Interval value to load, clamped to 1..16 |
| req_valid_i | input | 1 | Request present |
| req_time_i | input | 16 | Schedule time of the request |
| req_res_i | input | 3 | Resource code |
| req_commit_i | input | 1 | Reserve the cell if it is free |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_free_o | output | 1 | Addressed cell was free |
| rsp_conflict_o | output | 1 | Commit refused because the cell was busy or the code was invalid |
| rsp_slot_o | output | 4 | Row the request mapped to |

## Verification
The hardest situation to reach is a second claim on a cell through a different absolute time. This is a collision that only the modulo folding exposes. It has to be checked for every interval and every resource, and it must leave the other cells untouched. The stimulus sweeps each interval from 1 to 16 and each resource. It commits one full lap of times so that every row is taken, then a second lap offset by large multiples of the interval, which must all conflict. A bench model of the grid catches any write that reaches the wrong cell. Separate steps put a request in the same cycle as a clear or an interval load, drive out-of-range loads and resource codes, and use time values near the top of the 16-bit range.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int RES_COUNT = 6;
  localparam int RES_W     = 3;

  typedef enum logic [RES_W-1:0] {
    RES_ALU_A  = 3'd0,
    RES_ALU_B  = 3'd1,
    RES_MEM    = 3'd2,
    RES_BUS_A  = 3'd3,
    RES_BUS_B  = 3'd4,
    RES_BRANCH = 3'd5
  } res_e;

  function automatic logic res_is_valid(input logic [RES_W-1:0] code);
    return int'(code) < RES_COUNT;
  endfunction
endpackage

// File: rtl/mrt_ii_reg.sv
module mrt_ii_reg #(
  parameter int MAX_II = 16,
  parameter int IIW    = $clog2(MAX_II + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [IIW-1:0] val_i,
  output logic [IIW-1:0] ii_o
);
  localparam logic [IIW-1:0] II_MAX_V = IIW'(MAX_II);
  localparam logic [IIW-1:0] II_ONE   = IIW'(1);

  function automatic logic [IIW-1:0] clamp_ii(input logic [IIW-1:0] v);
    if (v == '0)          return II_ONE;
    else if (v > II_MAX_V) return II_MAX_V;
    else                   return v;
  endfunction

  logic [IIW-1:0] ii_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ii_q <= II_ONE;
    else if (load_i) ii_q <= clamp_ii(val_i);
  end

  assign ii_o = ii_q;

  assert_ii_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ii_q != '0) && (ii_q <= II_MAX_V));
endmodule

// File: rtl/mrt_slot_calc.sv
module mrt_slot_calc #(
  parameter int TIME_W = 16,
  parameter int MAX_II = 16,
  parameter int IIW    = $clog2(MAX_II + 1),
  parameter int SLOTW  = (MAX_II > 1) ? $clog2(MAX_II) : 1
) (
  input  logic [TIME_W-1:0] time_i,
  input  logic [IIW-1:0]    ii_i,
  output logic [SLOTW-1:0]  slot_o
);
  // restoring shift-subtract remainder; valid for any nonzero divisor
  function automatic logic [SLOTW-1:0] fold_time(input logic [TIME_W-1:0] t,
                                                 input logic [IIW-1:0] d);
    logic [IIW:0] rem;
    rem = '0;
    for (int i = TIME_W - 1; i >= 0; i--) begin
      rem = {rem[IIW-1:0], t[i]};
      if (rem >= {1'b0, d}) rem = rem - {1'b0, d};
    end
    return rem[SLOTW-1:0];
  endfunction

  assign slot_o = fold_time(time_i, ii_i);
endmodule

// File: rtl/mrt_grid.sv
module mrt_grid #(
  parameter int MAX_II = 16,
  parameter int SLOTW  = (MAX_II > 1) ? $clog2(MAX_II) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wipe_i,
  input  logic                     wr_en_i,
  input  logic [SLOTW-1:0]         slot_i,
  input  logic [mrt_pkg::RES_W-1:0] res_i,
  output logic                     busy_o
);
  import mrt_pkg::*;

  logic [MAX_II-1:0][RES_COUNT-1:0] cells;
  logic                             code_ok;

  assign code_ok = res_is_valid(res_i);
  assign busy_o  = code_ok ? cells[slot_i][res_i] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cells <= '0;
    else if (wipe_i)             cells <= '0;
    else if (wr_en_i && code_ok) cells[slot_i][res_i] <= 1'b1;
  end

  assert_wipe_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_i |=> (cells == '0));
  assert_cells_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wipe_i |=> ((cells & $past(cells)) == $past(cells)));
  assert_one_cell_per_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wipe_i |=> ($countones(cells) <= $countones($past(cells)) + 1));
endmodule

// File: rtl/mrt_unit.sv
module mrt_unit #(
  parameter int TIME_W = 16,
  parameter int MAX_II = 16,
  parameter int IIW    = $clog2(MAX_II + 1),
  parameter int SLOTW  = (MAX_II > 1) ? $clog2(MAX_II) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      ii_load_i,
  input  logic [IIW-1:0]            ii_val_i,
  input  logic                      req_valid_i,
  input  logic [TIME_W-1:0]         req_time_i,
  input  logic [mrt_pkg::RES_W-1:0] req_res_i,
  input  logic                      req_commit_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_free_o,
  output logic                      rsp_conflict_o,
  output logic [SLOTW-1:0]          rsp_slot_o
);
  logic [IIW-1:0]   ii_cur;
  logic [SLOTW-1:0] slot_now;
  logic             cell_busy;
  logic             accept;
  logic             grant;
  logic             wipe;

  assign wipe   = clr_i | ii_load_i;
  assign accept = req_valid_i & ~wipe;
  assign grant  = accept & req_commit_i & ~cell_busy;

  mrt_ii_reg #(.MAX_II(MAX_II), .IIW(IIW)) ii_reg_i (
    .clk(clk), .rst_n(rst_n), .load_i(ii_load_i), .val_i(ii_val_i), .ii_o(ii_cur)
  );

  mrt_slot_calc #(.TIME_W(TIME_W), .MAX_II(MAX_II), .IIW(IIW), .SLOTW(SLOTW)) slot_i (
    .time_i(req_time_i), .ii_i(ii_cur), .slot_o(slot_now)
  );

  mrt_grid #(.MAX_II(MAX_II), .SLOTW(SLOTW)) grid_i (
    .clk(clk), .rst_n(rst_n), .wipe_i(wipe), .wr_en_i(grant),
    .slot_i(slot_now), .res_i(req_res_i), .busy_o(cell_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o    <= 1'b0;
      rsp_free_o     <= 1'b0;
      rsp_conflict_o <= 1'b0;
      rsp_slot_o     <= '0;
    end else begin
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_free_o     <= ~cell_busy;
        rsp_conflict_o <= req_commit_i & cell_busy;
        rsp_slot_o     <= slot_now;
      end
    end
  end

  assert_rsp_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o == $past(accept));
  assert_slot_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> (IIW'(rsp_slot_o) < ii_cur));
  assert_conflict_not_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_conflict_o |-> !rsp_free_o);
  assert_wipe_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |-> !grant);
endmodule

// File: tb/mrt_unit_tb_top.sv
`timescale 1ns/1ps
module mrt_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0, ii_load_i = 1'b0, req_valid_i = 1'b0, req_commit_i = 1'b0;
  logic [4:0]  ii_val_i = '0;
  logic [15:0] req_time_i = '0;
  logic [2:0]  req_res_i = '0;
  logic        rsp_valid_o, rsp_free_o, rsp_conflict_o;
  logic [3:0]  rsp_slot_o;

  int checks = 0, errors = 0;
  int cur_ii = 1;
  bit model [16][8];
  bit done = 1'b0;

  always #10 clk = ~clk;

  mrt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .ii_load_i(ii_load_i), .ii_val_i(ii_val_i),
    .req_valid_i(req_valid_i), .req_time_i(req_time_i), .req_res_i(req_res_i),
    .req_commit_i(req_commit_i), .rsp_valid_o(rsp_valid_o), .rsp_free_o(rsp_free_o),
    .rsp_conflict_o(rsp_conflict_o), .rsp_slot_o(rsp_slot_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_wipe();
    for (int r = 0; r < 16; r++) for (int c = 0; c < 8; c++) model[r][c] = 1'b0;
  endtask

  // one request, response checked against the model at the next negedge
  task automatic req(input int t, input int res, input bit commit, input string tag);
    int  s;
    bit  busy;
    @(negedge clk);
    req_valid_i = 1'b1; req_time_i = 16'(t); req_res_i = 3'(res); req_commit_i = commit;
    @(negedge clk);
    req_valid_i = 1'b0; req_commit_i = 1'b0;
    s = t % cur_ii;
    busy = (res > 5) ? 1'b1 : model[s][res];
    chk(rsp_valid_o == 1'b1, {tag, " valid"}, int'(rsp_valid_o), 1);
    chk(int'(rsp_slot_o) == s, {tag, " slot"}, int'(rsp_slot_o), s);
    chk(rsp_free_o == !busy, {tag, " free"}, int'(rsp_free_o), int'(!busy));
    chk(rsp_conflict_o == (commit && busy), {tag, " conflict"}, int'(rsp_conflict_o),
        int'(commit && busy));
    if (commit && !busy) model[s][res] = 1'b1;
  endtask

  task automatic load_ii(input int v);
    @(negedge clk);
    ii_load_i = 1'b1; ii_val_i = 5'(v);
    @(negedge clk);
    ii_load_i = 1'b0;
    cur_ii = (v == 0) ? 1 : (v > 16 ? 16 : v);
    model_wipe();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    model_wipe();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid_o == 1'b0, "R1 no response after reset", int'(rsp_valid_o), 0);
    req(3, 2, 1'b0, "R1 interval one, empty grid");
    req(40001, 5, 1'b0, "R1 branch free");

    // R4/R5/R9 sweep: every interval, every resource, two laps
    for (int ii = 1; ii <= 16; ii++) begin
      load_ii(ii);
      for (int res = 0; res < 6; res++) begin
        for (int k = 0; k < ii; k++)
          req(k + ii * (res * 500 + 3), res, 1'b1, "R4 first lap commit");
        for (int k = 0; k < ii; k++)
          req(k + ii * (res * 500 + 71), res, 1'b1, "R5 second lap conflict");
      end
    end

    // R3/R5 query without commit writes nothing
    load_ii(5);
    req(7, 1, 1'b0, "R5 query only");
    req(12, 1, 1'b0, "R3 same cell still free");
    req(12, 1, 1'b1, "R4 commit");
    req(2, 1, 1'b0, "R3 busy seen via other time");
    req(2, 0, 1'b0, "R4 neighbour column untouched");
    req(3, 1, 1'b0, "R4 neighbour row untouched");

    // R8 invalid codes
    req(4, 6, 1'b1, "R8 code six");
    req(4, 7, 1'b0, "R8 code seven");
    for (int r = 0; r < 6; r++) req(9, r, 1'b0, "R8 no write from invalid code");

    // R6 clear with simultaneous request
    @(negedge clk);
    clr_i = 1'b1; req_valid_i = 1'b1; req_time_i = 16'd4; req_res_i = 3'd3; req_commit_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0; req_valid_i = 1'b0; req_commit_i = 1'b0;
    model_wipe();
    chk(rsp_valid_o == 1'b0, "R6 request during clear ignored", int'(rsp_valid_o), 0);
    req(12, 1, 1'b0, "R6 grid emptied");
    req(4, 3, 1'b0, "R6 ignored commit not written");

    // R7 load with simultaneous request, and clamping
    req(1, 2, 1'b1, "R7 setup commit");
    @(negedge clk);
    ii_load_i = 1'b1; ii_val_i = 5'd9; req_valid_i = 1'b1; req_time_i = 16'd10;
    req_res_i = 3'd0; req_commit_i = 1'b1;
    @(negedge clk);
    ii_load_i = 1'b0; req_valid_i = 1'b0; req_commit_i = 1'b0;
    cur_ii = 9; model_wipe();
    chk(rsp_valid_o == 1'b0, "R7 request during load ignored", int'(rsp_valid_o), 0);
    req(10, 0, 1'b0, "R7 ignored commit not written");
    req(1, 2, 1'b0, "R7 load emptied grid");
    load_ii(0);
    req(5, 4, 1'b0, "R7 zero taken as one");
    load_ii(20);
    req(17, 4, 1'b0, "R7 large taken as sixteen");
    load_ii(31);
    req(65535, 0, 1'b1, "R9 top time value");

    // R9 top-of-range times for several intervals
    for (int ii = 1; ii <= 16; ii += 3) begin
      load_ii(ii);
      for (int t = 65520; t <= 65535; t += 5) req(t, 2, 1'b1, "R9 high times");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule